// File: doc/BRIEF.md
# Variable-Width Page-Mode Bank Access Path

This block is the access path of a multi-bank embedded DRAM macro, with the cell array replaced by a behavioural register array. Each bank owns one row latch. A row must be sensed into that latch in one whole-page operation before any word of it can be used. After that, words come out of, or go into, the latched page through a column multiplexer. A page hit costs one cycle. A page miss costs a fixed two extra cycles for precharge and sense.

Every column request carries its own word width of 4, 8 or 16 bits. A stream of packet segments can therefore switch granularity from one access to the next without wasting page space. The column address counts in units of the chosen width. A per-bank power-down input drops the bank's open page and refuses traffic to the bank. After power-down is released, an explicit row open is still needed before the bank serves column accesses again. The cell contents survive power-down.

Requests are taken one at a time when `busy` is low. Every accepted request gives exactly one response pulse on `rspValid`, along with the hit flag, the error flag and the read word.

Top module: `pagemux_top`

## Requirements
- R1: After reset, `busy` and `rspValid` are low, no bank has an open page, and all cells read as zero. The first read of any bank is therefore a miss.
- R2: An open-row request (`reqOp`=0) accepted at clock edge N holds `busy` high after edges N and N+1. It gives a response after edge N+2 with `rspHit`=0, `rspErr`=0 and `rspData`=0. That row is then open in that bank.
- R3: A read (`reqOp`=1) or write (`reqOp`=2) to the row open in its bank responds after the accepting edge itself, with `rspHit`=1 and `busy` staying low. A read returns the word. A write returns zero.
- R4: A read or write to a bank with no open page, or with a different open row, responds two cycles later than a hit, with `rspHit`=0. It first senses the requested row, which then becomes the open row. A read still returns the correct word.
- R5: `reqWidth` codes 0, 1 and 2 select widths w of 4, 8 and 16 bits. The word at column c occupies page bits [c*w+w-1 : c*w]. It is returned zero-extended on `rspData`.
- R6: A write changes only the w page bits its column selects, using the low w bits of `reqData`. Words written at one width read back correctly at another width.
- R7: Each of the following is refused in the next cycle with `rspErr`=1, `rspHit`=0 and `rspData`=0, leaving the page state unchanged:
  - `reqOp`=3;
  - `reqWidth`=3 on a read or write;
  - a column at or beyond PAGE_BITS/w.
- R8: Each bank keeps its own open row. Accesses that alternate between open rows of different banks are all hits.
- R9: While `pwrDown` of a bank is high, every request to that bank is refused as in R7, and its open page is dropped. Other banks are unaffected.
- R10: After `pwrDown` falls, reads and writes to that bank are still refused until an open-row request succeeds. The cell contents are kept across power-down.
- R11: A request presented while `busy` is high is ignored. It produces no response and changes no cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present; taken when `busy` is low |
| reqOp | input | 2 | 0 open row, 1 read, 2 write, 3 invalid |
| reqBank | input | BANK_W | Target bank |
| reqRow | input | ROW_W | Target row |
| reqCol | input | COL_W | Column in units of the selected width |
| reqWidth | input | 2 | 0 x4, 1 x8, 2 x16, 3 invalid |
| reqData | input | 16 | Write data; low w bits used |
| pwrDown | input | NUM_BANKS | Per-bank power-down level |
| busy | output | 1 | Precharge/sense in progress; requests ignored |
| rspValid | output | 1 | One-cycle response pulse |
| rspHit | output | 1 | Response came from an already open page |
| rspErr | output | 1 | Request was refused |
| rspData | output | 16 | Read word, zero-extended; zero otherwise |

## Verification
The hardest situation to reach is a bank that has been powered down and released but not yet reopened. The ports show nothing about it: `pwrDown` is already low, and the cell contents must still be intact. The stimulus first writes a known word into a bank and then raises that bank's power-down while issuing requests to both banks. It then lowers power-down and tries a read, which must be refused. Only after that does it issue an open-row request and read the word back.

A second hard case is a request slipped in during a miss's busy window. The stimulus holds `reqValid` high in that window with a write. It then proves the write was dropped by reading the target column back after the miss completes.

// File: rtl/pagemux_pkg.sv
package pagemux_pkg;

  // Widest column word; the three widths 4/8/16 are the block's function.
  localparam int MAX_W = 16;

  typedef enum logic [1:0] {
    OP_OPEN  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_NONE  = 2'd3
  } pm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRECH = 2'd1,
    ST_ACT   = 2'd2
  } pm_state_e;

  // Strobes from control to datapath for one clock edge.
  typedef struct packed {
    logic sense;     // copy selected row of cells into the bank latch
    logic access;    // column read or write on the selected latch
    logic write;     // qualifies access as a write
    logic hit;       // access served without sensing
    logic fail;      // refused request, error response
    logic openDone;  // open-row request completes
  } pm_strobe_t;

endpackage

// File: rtl/pagemux_bank_state.sv
module pagemux_bank_state #(
  parameter int ROW_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwrDown,
  input  logic             senseHere,
  input  logic [ROW_W-1:0] senseRow,
  output logic             isOpen,
  output logic [ROW_W-1:0] openRow,
  output logic             asleep
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isOpen  <= 1'b0;
      openRow <= '0;
      asleep  <= 1'b0;
    end else if (pwrDown) begin
      isOpen <= 1'b0;
      asleep <= 1'b1;
    end else if (senseHere) begin
      isOpen  <= 1'b1;
      openRow <= senseRow;
      asleep  <= 1'b0;
    end
  end

endmodule

// File: rtl/pagemux_ctrl.sv
module pagemux_ctrl
  import pagemux_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int PAGE_BITS = 64,
  parameter int BANK_W    = 1,
  parameter int ROW_W     = 2,
  parameter int COL_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [COL_W-1:0] reqCol,
  input  logic [1:0]       reqWidth,
  input  logic [MAX_W-1:0] reqData,
  input  logic [NUM_BANKS-1:0] pwrDown,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic [NUM_BANKS-1:0] bankAsleep,
  input  logic [ROW_W-1:0] bankRow [NUM_BANKS],
  output logic             busy,
  output pm_strobe_t       strobe,
  output logic [BANK_W-1:0] selBank,
  output logic [ROW_W-1:0] selRow,
  output logic [COL_W-1:0] selCol,
  output logic [1:0]       selWidth,
  output logic [MAX_W-1:0] selData
);

  localparam int LIM4  = PAGE_BITS / 4;
  localparam int LIM8  = PAGE_BITS / 8;
  localparam int LIM16 = PAGE_BITS / 16;

  pm_state_e state, stateNext;
  pm_op_e    op, lOp;
  logic [BANK_W-1:0] lBank;
  logic [ROW_W-1:0]  lRow;
  logic [COL_W-1:0]  lCol;
  logic [1:0]        lWidth;
  logic [MAX_W-1:0]  lData;

  logic bankOk, curOpen, curAsleep, pdNow, colOk, reqErr, reqHit, accept;
  logic [ROW_W-1:0] curRow;

  assign op     = pm_op_e'(reqOp);
  assign accept = reqValid && (state == ST_IDLE);
  assign busy   = (state != ST_IDLE);

  always_comb begin
    bankOk    = 1'b0;
    curOpen   = 1'b0;
    curAsleep = 1'b0;
    pdNow     = 1'b0;
    curRow    = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (reqBank == BANK_W'(b)) begin
        bankOk    = 1'b1;
        curOpen   = bankOpen[b];
        curAsleep = bankAsleep[b];
        pdNow     = pwrDown[b];
        curRow    = bankRow[b];
      end
    end
  end

  always_comb begin
    unique case (reqWidth)
      2'd0:    colOk = (32'(reqCol) < 32'(LIM4));
      2'd1:    colOk = (32'(reqCol) < 32'(LIM8));
      2'd2:    colOk = (32'(reqCol) < 32'(LIM16));
      default: colOk = 1'b0;
    endcase
  end

  assign reqErr = !bankOk || pdNow || (op == OP_NONE) ||
                  ((op != OP_OPEN) && (curAsleep || !colOk));
  assign reqHit = curOpen && (curRow == reqRow);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (reqErr) begin
            strobe.fail = 1'b1;
          end else if ((op != OP_OPEN) && reqHit) begin
            strobe.access = 1'b1;
            strobe.write  = (op == OP_WRITE);
            strobe.hit    = 1'b1;
          end else begin
            stateNext = ST_PRECH;
          end
        end
      end
      ST_PRECH: begin
        strobe.sense = 1'b1;
        stateNext    = ST_ACT;
      end
      ST_ACT: begin
        if (lOp == OP_OPEN) begin
          strobe.openDone = 1'b1;
        end else begin
          strobe.access = 1'b1;
          strobe.write  = (lOp == OP_WRITE);
        end
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      lOp    <= OP_OPEN;
      lBank  <= '0;
      lRow   <= '0;
      lCol   <= '0;
      lWidth <= '0;
      lData  <= '0;
    end else begin
      state <= stateNext;
      if (accept) begin
        lOp    <= op;
        lBank  <= reqBank;
        lRow   <= reqRow;
        lCol   <= reqCol;
        lWidth <= reqWidth;
        lData  <= reqData;
      end
    end
  end

  // While idle the live request addresses the datapath; otherwise the held one.
  assign selBank  = busy ? lBank  : reqBank;
  assign selRow   = busy ? lRow   : reqRow;
  assign selCol   = busy ? lCol   : reqCol;
  assign selWidth = busy ? lWidth : reqWidth;
  assign selData  = busy ? lData  : reqData;

endmodule

// File: rtl/pagemux_datapath.sv
module pagemux_datapath
  import pagemux_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ROWS      = 4,
  parameter int PAGE_BITS = 64,
  parameter int BANK_W    = 1,
  parameter int ROW_W     = 2,
  parameter int COL_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  pm_strobe_t        strobe,
  input  logic [BANK_W-1:0] selBank,
  input  logic [ROW_W-1:0]  selRow,
  input  logic [COL_W-1:0]  selCol,
  input  logic [1:0]        selWidth,
  input  logic [MAX_W-1:0]  selData,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspErr,
  output logic [MAX_W-1:0]  rspData
);

  localparam int LANES = 3;

  logic [PAGE_BITS-1:0] latchAll [NUM_BANKS];
  logic [PAGE_BITS-1:0] selPage, newPage;
  logic [MAX_W-1:0]     word;
  logic [MAX_W-1:0]     laneWord [LANES];
  logic [PAGE_BITS-1:0] laneNew  [LANES];

  always_comb begin
    selPage = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (selBank == BANK_W'(b)) selPage = latchAll[b];
    end
  end

  // One extract/merge lane per word width.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int LW = 4 << k;
    localparam logic [MAX_W-1:0] MASK = MAX_W'((1 << LW) - 1);
    logic [31:0] sh;
    assign sh          = 32'(selCol) * LW;
    assign laneWord[k] = MAX_W'(selPage >> sh) & MASK;
    assign laneNew[k]  = (selPage & ~(PAGE_BITS'(MASK) << sh)) |
                         (PAGE_BITS'(selData & MASK) << sh);
  end

  always_comb begin
    unique case (selWidth)
      2'd0:    begin word = laneWord[0]; newPage = laneNew[0]; end
      2'd1:    begin word = laneWord[1]; newPage = laneNew[1]; end
      default: begin word = laneWord[2]; newPage = laneNew[2]; end
    endcase
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [PAGE_BITS-1:0] cells [ROWS];
    logic [PAGE_BITS-1:0] pageQ;
    logic here;
    assign here        = (selBank == BANK_W'(b));
    assign latchAll[b] = pageQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pageQ <= '0;
        for (int r = 0; r < ROWS; r++) cells[r] <= '0;
      end else if (here && strobe.sense) begin
        pageQ <= cells[selRow];
      end else if (here && strobe.access && strobe.write) begin
        pageQ         <= newPage;
        cells[selRow] <= newPage;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspErr   <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.access || strobe.fail || strobe.openDone;
      rspHit   <= strobe.hit;
      rspErr   <= strobe.fail;
      rspData  <= (strobe.access && !strobe.write) ? word : '0;
    end
  end

endmodule

// File: rtl/pagemux_top.sv
module pagemux_top
  import pagemux_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ROWS      = 4,
  parameter int PAGE_BITS = 64,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W    = $clog2(PAGE_BITS / 4)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [1:0]           reqOp,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [ROW_W-1:0]     reqRow,
  input  logic [COL_W-1:0]     reqCol,
  input  logic [1:0]           reqWidth,
  input  logic [15:0]          reqData,
  input  logic [NUM_BANKS-1:0] pwrDown,
  output logic                 busy,
  output logic                 rspValid,
  output logic                 rspHit,
  output logic                 rspErr,
  output logic [15:0]          rspData
);

  pm_strobe_t        strobe;
  logic [BANK_W-1:0] selBank;
  logic [ROW_W-1:0]  selRow;
  logic [COL_W-1:0]  selCol;
  logic [1:0]        selWidth;
  logic [MAX_W-1:0]  selData;
  logic [NUM_BANKS-1:0] bankOpen, bankAsleep;
  logic [ROW_W-1:0]  bankRow [NUM_BANKS];

  pagemux_ctrl #(
    .NUM_BANKS(NUM_BANKS), .PAGE_BITS(PAGE_BITS),
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .reqWidth(reqWidth), .reqData(reqData), .pwrDown(pwrDown),
    .bankOpen(bankOpen), .bankAsleep(bankAsleep), .bankRow(bankRow),
    .busy(busy), .strobe(strobe), .selBank(selBank), .selRow(selRow),
    .selCol(selCol), .selWidth(selWidth), .selData(selData)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_state
    pagemux_bank_state #(.ROW_W(ROW_W)) u_state (
      .clk(clk), .rstN(rstN), .pwrDown(pwrDown[b]),
      .senseHere(strobe.sense && (selBank == BANK_W'(b))),
      .senseRow(selRow), .isOpen(bankOpen[b]),
      .openRow(bankRow[b]), .asleep(bankAsleep[b])
    );
  end

  pagemux_datapath #(
    .NUM_BANKS(NUM_BANKS), .ROWS(ROWS), .PAGE_BITS(PAGE_BITS),
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selBank(selBank),
    .selRow(selRow), .selCol(selCol), .selWidth(selWidth),
    .selData(selData), .rspValid(rspValid), .rspHit(rspHit),
    .rspErr(rspErr), .rspData(rspData)
  );

endmodule

// File: rtl/pagemux_chk.sv
module pagemux_chk #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic [BANK_W-1:0]    reqBank,
  input logic [NUM_BANKS-1:0] pwrDown,
  input logic                 busy,
  input logic                 rspValid,
  input logic                 rspHit,
  input logic                 rspErr,
  input logic [15:0]          rspData
);

  logic [1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= (busyRun == 2'd3) ? 2'd3 : busyRun + 2'd1;
    else           busyRun <= '0;
  end

  // R2 R4
  busy_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= 2'd2);

  // R4
  miss_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (rspValid && !rspHit && !rspErr));

  // R3
  hit_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit) |-> $past(reqValid && !busy));

  // R7
  err_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> (!rspHit && rspData == 16'h0));

  // R9
  pd_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && pwrDown[reqBank]) |=> (rspValid && rspErr));

  // R11
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($past(reqValid && !busy) || $past(busy)));

endmodule

bind pagemux_top pagemux_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBank(reqBank),
  .pwrDown(pwrDown), .busy(busy), .rspValid(rspValid), .rspHit(rspHit),
  .rspErr(rspErr), .rspData(rspData)
);

// File: tb/pagemux_top_test.sv
module pagemux_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [1:0] OPEN = 2'd0, RD = 2'd1, WR = 2'd2, BAD = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic        bank;
    logic [1:0]  row;
    logic [3:0]  col;
    logic [1:0]  wid;
    logic [15:0] wd;
    logic [1:0]  pd;
    logic        eErr;
    logic        eHit;
    logic [15:0] eData;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{OPEN, 1'b0, 2'd1, 4'd0,  2'd2, 16'h0000, 2'b00, 1'b0, 1'b0, 16'h0000, 4'd2},  // R2
    '{WR,   1'b0, 2'd1, 4'd0,  2'd2, 16'hBEEF, 2'b00, 1'b0, 1'b1, 16'h0000, 4'd3},  // R3
    '{RD,   1'b0, 2'd1, 4'd0,  2'd2, 16'h0000, 2'b00, 1'b0, 1'b1, 16'hBEEF, 4'd3},  // R3
    '{RD,   1'b0, 2'd1, 4'd1,  2'd0, 16'h0000, 2'b00, 1'b0, 1'b1, 16'h000E, 4'd5},  // R5
    '{RD,   1'b0, 2'd1, 4'd1,  2'd1, 16'h0000, 2'b00, 1'b0, 1'b1, 16'h00BE, 4'd5},  // R5
    '{WR,   1'b0, 2'd1, 4'd2,  2'd0, 16'hFFF5, 2'b00, 1'b0, 1'b1, 16'h0000, 4'd6},  // R6
    '{RD,   1'b0, 2'd1, 4'd0,  2'd2, 16'h0000, 2'b00, 1'b0, 1'b1, 16'hB5EF, 4'd6},  // R6
    '{RD,   1'b0, 2'd1, 4'd3,  2'd2, 16'h0000, 2'b00, 1'b0, 1'b1, 16'h0000, 4'd7},  // R7
    '{RD,   1'b0, 2'd1, 4'd4,  2'd2, 16'h0000, 2'b00, 1'b1, 1'b0, 16'h0000, 4'd7},  // R7
    '{RD,   1'b0, 2'd1, 4'd8,  2'd1, 16'h0000, 2'b00, 1'b1, 1'b0, 16'h0000, 4'd7},  // R7
    '{RD,   1'b0, 2'd1, 4'd15, 2'd0, 16'h0000, 2'b00, 1'b0, 1'b1, 16'h0000, 4'd7},  // R7
    '{RD,   1'b0, 2'd1, 4'd0,  2'd3, 16'h0000, 2'b00, 1'b1, 1'b0, 16'h0000, 4'd7},  // R7
    '{BAD,  1'b0, 2'd1, 4'd0,  2'd2, 16'h0000, 2'b00, 1'b1, 1'b0, 16'h0000, 4'd7},  // R7
    '{RD,   1'b0, 2'd2, 4'd0,  2'd2, 16'h0000, 2'b00, 1'b0, 1'b0, 16'h0000, 4'd4},  // R4
    '{RD,   1'b0, 2'd1, 4'd0,  2'd2, 16'h0000, 2'b00, 1'b0, 1'b0, 16'hB5EF, 4'd4},  // R4
    '{WR,   1'b1, 2'd1, 4'd3,  2'd2, 16'h1234, 2'b00, 1'b0, 1'b0, 16'h0000, 4'd8},  // R8
    '{RD,   1'b0, 2'd1, 4'd0,  2'd2, 16'h0000, 2'b00, 1'b0, 1'b1, 16'hB5EF, 4'd8},  // R8
    '{RD,   1'b1, 2'd1, 4'd3,  2'd2, 16'h0000, 2'b00, 1'b0, 1'b1, 16'h1234, 4'd8},  // R8
    '{RD,   1'b1, 2'd1, 4'd3,  2'd2, 16'h0000, 2'b10, 1'b1, 1'b0, 16'h0000, 4'd9},  // R9
    '{OPEN, 1'b1, 2'd1, 4'd0,  2'd2, 16'h0000, 2'b10, 1'b1, 1'b0, 16'h0000, 4'd9},  // R9
    '{RD,   1'b0, 2'd1, 4'd0,  2'd2, 16'h0000, 2'b10, 1'b0, 1'b1, 16'hB5EF, 4'd9},  // R9
    '{RD,   1'b1, 2'd1, 4'd3,  2'd2, 16'h0000, 2'b00, 1'b1, 1'b0, 16'h0000, 4'd10}, // R10
    '{OPEN, 1'b1, 2'd1, 4'd0,  2'd2, 16'h0000, 2'b00, 1'b0, 1'b0, 16'h0000, 4'd10}, // R10
    '{RD,   1'b1, 2'd1, 4'd3,  2'd2, 16'h0000, 2'b00, 1'b0, 1'b1, 16'h1234, 4'd10}  // R10
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = '0;
  logic        reqBank = '0;
  logic [1:0]  reqRow = '0;
  logic [3:0]  reqCol = '0;
  logic [1:0]  reqWidth = '0;
  logic [15:0] reqData = '0;
  logic [1:0]  pwrDown = '0;
  logic        busy, rspValid, rspHit, rspErr;
  logic [15:0] rspData;

  int checks = 0;
  int fails  = 0;

  pagemux_top uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .reqWidth(reqWidth), .reqData(reqData), .pwrDown(pwrDown),
    .busy(busy), .rspValid(rspValid), .rspHit(rspHit),
    .rspErr(rspErr), .rspData(rspData)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic doReq(input logic [1:0] op, input logic bank, input logic [1:0] row,
                       input logic [3:0] col, input logic [1:0] wid, input logic [15:0] wd,
                       input logic [1:0] pd, input logic eErr, input logic eHit,
                       input logic [15:0] eData, input int req);
    int lat;
    int expLat;
    expLat = (eErr || eHit) ? 1 : 3;
    @(negedge clk);
    pwrDown  = pd;
    reqOp    = op;
    reqBank  = bank;
    reqRow   = row;
    reqCol   = col;
    reqWidth = wid;
    reqData  = wd;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!rspValid && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    check(rspValid == 1'b1, req, "response present", 32'(rspValid), 32'd1);
    check(lat == expLat, req, "latency", 32'(lat), 32'(expLat));
    check(rspErr == eErr, req, "error flag", 32'(rspErr), 32'(eErr));
    check(rspHit == eHit, req, "hit flag", 32'(rspHit), 32'(eHit));
    check(rspData == eData, req, "data", 32'(rspData), 32'(eData));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle after reset, first access is a miss reading zero
    check(busy == 1'b0, 1, "busy after reset", 32'(busy), 32'd0);
    check(rspValid == 1'b0, 1, "rspValid after reset", 32'(rspValid), 32'd0);
    doReq(RD, 1'b0, 2'd0, 4'd0, 2'd2, 16'h0, 2'b00, 1'b0, 1'b0, 16'h0, 1);

    for (int i = 0; i < NV; i++) begin
      doReq(VECS[i].op, VECS[i].bank, VECS[i].row, VECS[i].col, VECS[i].wid,
            VECS[i].wd, VECS[i].pd, VECS[i].eErr, VECS[i].eHit, VECS[i].eData,
            int'(VECS[i].req));
    end

    // R11: a write offered during a miss is dropped
    @(negedge clk);
    reqOp = RD; reqBank = 1'b0; reqRow = 2'd3; reqCol = 4'd0; reqWidth = 2'd2;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(busy == 1'b1, 11, "busy during miss", 32'(busy), 32'd1);
    reqOp = WR; reqRow = 2'd1; reqData = 16'h0000;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid == 1'b0, 11, "no early response", 32'(rspValid), 32'd0);
    @(negedge clk);
    check(rspValid == 1'b1 && rspHit == 1'b0, 11, "miss response", 32'(rspValid), 32'd1);
    @(negedge clk);
    check(rspValid == 1'b0, 11, "no response for ignored write", 32'(rspValid), 32'd0);
    doReq(RD, 1'b0, 2'd1, 4'd0, 2'd2, 16'h0, 2'b00, 1'b0, 1'b0, 16'hB5EF, 11);

    finishRun();
  end

endmodule